// File: doc/BRIEF.md
# Sensor Register Slave with Word Pointer

This block is the byte-level slave for a temperature-sensor register file on a two-wire SMBus/I2C bus. A bit-level front end below it turns the wire activity into START, STOP and byte events. This block decides whether each byte is acknowledged and supplies the bytes that the master reads. A register-file port sits above it.

The slave answers to the device code `0011` followed by three pin-selected bits. An internal pointer selects one 16-bit register. A master can do four things: write the pointer alone, write the pointer and then a 16-bit word, read the word at the pointer it already set, or set the pointer and then read through a repeated START. Words always move high byte first.

Each register has an access kind: read/write, read-only or write-only. A write to a read-only register is acknowledged but discarded. A read of a write-only register returns zero. If the bus is held low for longer than a programmable number of cycles while a transaction is open, the slave drops back to idle and releases its data line.

Top module: `sensor_reg_slave`

## Requirements
- R1: An address byte whose upper seven bits equal `0011` followed by `addrPins` (bit 0 is read=1/write=0) is acknowledged. Any other address byte is not acknowledged, and every later byte up to the next START is not acknowledged either.
- R2: For every `rxValid` pulse, `ackValid` is high exactly one cycle later, with `ackBit` giving the decision. The slave never stalls the bus.
- R3: After reset `regPtr` is 0. A pointer byte whose bits above the low `PTR_W` bits are all zero is acknowledged and loads those low bits into `regPtr`. A pointer byte with any upper bit set is not acknowledged and leaves `regPtr` unchanged. `regPtr` keeps its value across transactions.
- R4: After the pointer byte, a write takes two data bytes, high byte first. One cycle after the second data byte, `regWrEn` pulses for one cycle with `regWrData` = {first, second}. Any further data byte is not acknowledged.
- R5: A word written to a register whose bit is set in `RO_MASK` is acknowledged byte for byte, but `regWrEn` does not pulse.
- R6: An acknowledged address byte with read set captures the word at `regPtr`. From the next cycle on, `txData` shows the high byte. Each master ACK (`txAckValid` with `txNack`=0) advances `txData` to the other byte, alternating high and low.
- R7: A read of a register whose bit is set in `WO_MASK` returns 0x0000.
- R8: A master NACK (`txAckValid` with `txNack`=1) ends the read. From the next cycle `txActive` is 0, `txData` is 0xFF, and further bytes are not acknowledged until a START.
- R9: A STOP returns the slave to idle, with `txActive` low. A START in any state, including a repeated START during a transaction, restarts the address phase and keeps the pointer.
- R10: While the slave is not idle, if `lineLow` is high for `TIMEOUT_CYC` consecutive cycles, `timeoutEvt` pulses in the cycle after the last of them. The slave is then idle: `txActive` is 0 and bytes are not acknowledged until a START. A shorter low period has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrPins | input | 3 | Pin-selected low address bits |
| busStart | input | 1 | START or repeated START seen (one-cycle pulse) |
| busStop | input | 1 | STOP seen (one-cycle pulse) |
| rxValid | input | 1 | A byte from the master is complete |
| rxData | input | 8 | Byte from the master, MSB already first on the wire |
| txAckValid | input | 1 | Master's acknowledge slot after a byte sent by the slave |
| txNack | input | 1 | 1 when that slot held NACK |
| lineLow | input | 1 | SCL or SDA is currently held low |
| regRdData | input | 16 | Register-file word at `regPtr` |
| ackValid | output | 1 | Acknowledge decision valid |
| ackBit | output | 1 | 1 = drive ACK, 0 = leave the line released |
| txData | output | 8 | Byte to send while reading; 0xFF otherwise |
| txActive | output | 1 | Slave is in a read transfer |
| regPtr | output | PTR_W | Latched register pointer |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 16 | Word to write |
| timeoutEvt | output | 1 | One-cycle pulse when the bus timeout fires |

## Verification
The bench builds the slave with `PTR_W`=3, `RO_MASK`=0x21, `WO_MASK`=0x04 and `TIMEOUT_CYC`=40. The 40-cycle limit makes it possible to hold the bus one cycle short of the limit, and then past it, within a short run, so the exact expiry cycle can be pinned down. With eight registers of all three access kinds, random writes, pointer-only updates and repeated-start reads reach every pointer value. They also reach the ignored write, the zero read and the rejected wide pointer, all checked against a model register file.

// File: rtl/sensor_reg_slave_pkg.sv
package sensor_reg_slave_pkg;

  localparam logic [3:0] DEV_CODE   = 4'b0011;
  localparam int         BYTE_W     = 8;
  localparam int         WORD_BYTES = 2;
  localparam int         WORD_W     = BYTE_W * WORD_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WHI,
    ST_WLO,
    ST_READ,
    ST_SKIP
  } slvState_t;

  typedef enum logic [1:0] {
    ACC_RW,
    ACC_RO,
    ACC_WO
  } accKind_t;

  typedef struct packed {
    logic loadPtr;
    logic loadHi;
    logic writeReg;
    logic latchRead;
    logic clearSel;
    logic toggleSel;
  } dpStrobe_t;

endpackage

// File: rtl/sensor_reg_slave_ctrl.sv
module sensor_reg_slave_ctrl
  import sensor_reg_slave_pkg::*;
#(
  parameter int PTR_W       = 3,
  parameter int TIMEOUT_CYC = 2500000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  addrPins,
  input  logic        busStart,
  input  logic        busStop,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        txAckValid,
  input  logic        txNack,
  input  logic        lineLow,
  input  logic        curRo,
  output dpStrobe_t   stb,
  output logic        ackValid,
  output logic        ackBit,
  output logic        txActive,
  output logic        timeoutEvt
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  slvState_t        stateQ, stateD;
  logic [CNT_W-1:0] lowCntQ;
  logic             toFire;
  logic             ackD;
  logic             addrHit;
  logic             ptrOk;

  assign addrHit = (rxData[7:1] == {DEV_CODE, addrPins});
  assign ptrOk   = ((rxData >> PTR_W) == 8'd0);
  assign toFire  = lineLow && (stateQ != ST_IDLE) &&
                   (lowCntQ == CNT_W'(TIMEOUT_CYC - 1));

  // Bus-low watchdog: counts consecutive low cycles of an open transaction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCntQ <= '0;
    end else if (!lineLow || stateQ == ST_IDLE || toFire) begin
      lowCntQ <= '0;
    end else begin
      lowCntQ <= lowCntQ + 1'b1;
    end
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    ackD   = 1'b0;
    if (toFire) begin
      stateD = ST_IDLE;
    end else if (busStop) begin
      stateD = ST_IDLE;
    end else if (busStart) begin
      stateD       = ST_ADDR;
      stb.clearSel = 1'b1;
    end else if (rxValid) begin
      case (stateQ)
        ST_ADDR: begin
          if (addrHit) begin
            ackD = 1'b1;
            if (rxData[0]) begin
              stateD        = ST_READ;
              stb.latchRead = 1'b1;
              stb.clearSel  = 1'b1;
            end else begin
              stateD = ST_PTR;
            end
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_PTR: begin
          if (ptrOk) begin
            ackD        = 1'b1;
            stb.loadPtr = 1'b1;
            stateD      = ST_WHI;
          end else begin
            stateD = ST_SKIP;
          end
        end
        ST_WHI: begin
          ackD       = 1'b1;
          stb.loadHi = 1'b1;
          stateD     = ST_WLO;
        end
        ST_WLO: begin
          ackD         = 1'b1;
          stb.writeReg = !curRo;
          stateD       = ST_SKIP;
        end
        default: begin
          ackD = 1'b0;
        end
      endcase
    end else if (txAckValid && stateQ == ST_READ) begin
      if (txNack) begin
        stateD = ST_SKIP;
      end else begin
        stb.toggleSel = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      ackValid   <= 1'b0;
      ackBit     <= 1'b0;
      timeoutEvt <= 1'b0;
    end else begin
      stateQ     <= stateD;
      ackValid   <= rxValid;
      ackBit     <= ackD;
      timeoutEvt <= toFire;
    end
  end

  assign txActive = (stateQ == ST_READ);

endmodule

// File: rtl/sensor_reg_slave_dp.sv
module sensor_reg_slave_dp
  import sensor_reg_slave_pkg::*;
#(
  parameter int                     PTR_W   = 3,
  parameter logic [(1<<PTR_W)-1:0]  RO_MASK = 8'b0010_0001,
  parameter logic [(1<<PTR_W)-1:0]  WO_MASK = 8'b0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [7:0]        rxData,
  input  logic [WORD_W-1:0] regRdData,
  input  logic              txActive,
  output logic [PTR_W-1:0]  regPtr,
  output logic              regWrEn,
  output logic [WORD_W-1:0] regWrData,
  output logic [7:0]        txData,
  output logic              curRo
);

  localparam int NUM_REGS = 1 << PTR_W;
  localparam int SEL_W    = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  accKind_t          accKind [NUM_REGS];
  logic [7:0]        lane    [WORD_BYTES];
  logic [PTR_W-1:0]  ptrQ;
  logic [7:0]        hiQ;
  logic [WORD_W-1:0] readWordQ;
  logic [SEL_W-1:0]  selQ;
  logic [SEL_W-1:0]  laneIdx;
  logic              isWo;

  // Per-register access kind decoded from the masks (read-only wins)
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_acc
    assign accKind[i] = RO_MASK[i] ? ACC_RO :
                        (WO_MASK[i] ? ACC_WO : ACC_RW);
  end

  // Byte lanes of the captured read word, lane 0 is least significant
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign lane[b] = readWordQ[b*BYTE_W +: BYTE_W];
  end

  assign curRo = (accKind[ptrQ] == ACC_RO);
  assign isWo  = (accKind[ptrQ] == ACC_WO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ      <= '0;
      hiQ       <= '0;
      readWordQ <= '0;
      selQ      <= '0;
      regWrEn   <= 1'b0;
      regWrData <= '0;
    end else begin
      regWrEn <= stb.writeReg;
      if (stb.loadPtr)   ptrQ      <= rxData[PTR_W-1:0];
      if (stb.loadHi)    hiQ       <= rxData;
      if (stb.writeReg)  regWrData <= {hiQ, rxData};
      if (stb.latchRead) readWordQ <= isWo ? '0 : regRdData;
      if (stb.clearSel) begin
        selQ <= '0;
      end else if (stb.toggleSel) begin
        selQ <= (selQ == SEL_W'(WORD_BYTES - 1)) ? '0 : selQ + 1'b1;
      end
    end
  end

  assign laneIdx = SEL_W'(WORD_BYTES - 1) - selQ;
  assign txData  = txActive ? lane[laneIdx] : 8'hFF;
  assign regPtr  = ptrQ;

endmodule

// File: rtl/sensor_reg_slave.sv
module sensor_reg_slave
  import sensor_reg_slave_pkg::*;
#(
  parameter int                     PTR_W       = 3,
  parameter logic [(1<<PTR_W)-1:0]  RO_MASK     = 8'b0010_0001,
  parameter logic [(1<<PTR_W)-1:0]  WO_MASK     = 8'b0000_0100,
  parameter int                     TIMEOUT_CYC = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addrPins,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              txAckValid,
  input  logic              txNack,
  input  logic              lineLow,
  input  logic [15:0]       regRdData,
  output logic              ackValid,
  output logic              ackBit,
  output logic [7:0]        txData,
  output logic              txActive,
  output logic [PTR_W-1:0]  regPtr,
  output logic              regWrEn,
  output logic [15:0]       regWrData,
  output logic              timeoutEvt
);

  dpStrobe_t stb;
  logic      curRo;

  sensor_reg_slave_ctrl #(
    .PTR_W       (PTR_W),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addrPins   (addrPins),
    .busStart   (busStart),
    .busStop    (busStop),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .txAckValid (txAckValid),
    .txNack     (txNack),
    .lineLow    (lineLow),
    .curRo      (curRo),
    .stb        (stb),
    .ackValid   (ackValid),
    .ackBit     (ackBit),
    .txActive   (txActive),
    .timeoutEvt (timeoutEvt)
  );

  sensor_reg_slave_dp #(
    .PTR_W   (PTR_W),
    .RO_MASK (RO_MASK),
    .WO_MASK (WO_MASK)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rxData    (rxData),
    .regRdData (regRdData),
    .txActive  (txActive),
    .regPtr    (regPtr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .txData    (txData),
    .curRo     (curRo)
  );

endmodule

// File: rtl/sensor_reg_slave_chk.sv
module sensor_reg_slave_chk #(
  parameter int                     PTR_W   = 3,
  parameter logic [(1<<PTR_W)-1:0]  RO_MASK = 8'b0010_0001
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             busStop,
  input logic             ackValid,
  input logic             ackBit,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regPtr,
  input logic             txActive,
  input logic             timeoutEvt
);

  p_ack_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> ackValid);

  p_ack_has_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(rxValid));

  p_ptr_moves_on_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regPtr) |-> (ackValid && ackBit));

  p_write_with_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (ackValid && ackBit));

  p_ro_never_written_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !RO_MASK[regPtr]);

  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    busStop |=> !txActive);

  p_timeout_releases_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutEvt |-> !txActive);

endmodule

bind sensor_reg_slave sensor_reg_slave_chk #(
  .PTR_W   (PTR_W),
  .RO_MASK (RO_MASK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rxValid    (rxValid),
  .busStop    (busStop),
  .ackValid   (ackValid),
  .ackBit     (ackBit),
  .regWrEn    (regWrEn),
  .regPtr     (regPtr),
  .txActive   (txActive),
  .timeoutEvt (timeoutEvt)
);

// File: tb/sensor_reg_slave_test.sv
module sensor_reg_slave_test;

  localparam int         CLK_PERIOD = 10;
  localparam int         PTR_W      = 3;
  localparam int         NREG       = 1 << PTR_W;
  localparam logic [7:0] RO_M       = 8'b0010_0001;
  localparam logic [7:0] WO_M       = 8'b0000_0100;
  localparam int         TO_CYC     = 40;
  localparam logic [2:0] PINS       = 3'b101;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             busStart = 0, busStop = 0, rxValid = 0;
  logic [7:0]       rxData = 0;
  logic             txAckValid = 0, txNack = 0, lineLow = 0;
  logic [15:0]      regRdData;
  logic             ackValid, ackBit, txActive, regWrEn, timeoutEvt;
  logic [7:0]       txData;
  logic [PTR_W-1:0] regPtr;
  logic [15:0]      regWrData;

  logic [15:0] regFile [NREG];
  logic [15:0] expRegs [NREG];
  int          expPtr = 0;
  int          total = 0, failed = 0, cyc = 0, wrCount = 0;
  logic        lastAckV, lastAck, lastWrEn;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_reg_slave #(
    .PTR_W(PTR_W), .RO_MASK(RO_M), .WO_MASK(WO_M), .TIMEOUT_CYC(TO_CYC)
  ) uut (
    .clk(clk), .rstN(rstN), .addrPins(PINS), .busStart(busStart),
    .busStop(busStop), .rxValid(rxValid), .rxData(rxData),
    .txAckValid(txAckValid), .txNack(txNack), .lineLow(lineLow),
    .regRdData(regRdData), .ackValid(ackValid), .ackBit(ackBit),
    .txData(txData), .txActive(txActive), .regPtr(regPtr),
    .regWrEn(regWrEn), .regWrData(regWrData), .timeoutEvt(timeoutEvt)
  );

  // Bench-side register file behind the slave
  assign regRdData = regFile[regPtr];
  always @(posedge clk) begin
    if (regWrEn) begin
      regFile[regPtr] <= regWrData;
      wrCount <= wrCount + 1;
    end
  end

  function automatic logic [7:0] addrByte(input logic [2:0] p, input logic rd);
    return {4'b0011, p, rd};
  endfunction

  function automatic logic [15:0] expRead(input int p);
    return WO_M[p] ? 16'h0000 : expRegs[p];
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total  = total + 1;
      failed = failed + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      failed = failed + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    busStart = 1; @(negedge clk); busStart = 0;
  endtask

  task automatic pulseStop();
    busStop = 1; @(negedge clk); busStop = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxData = b; rxValid = 1;
    @(negedge clk);
    rxValid = 0;
    lastAckV = ackValid; lastAck = ackBit; lastWrEn = regWrEn;
    chk("R2 ackValid one cycle after byte", {31'd0, lastAckV}, 32'd1);
  endtask

  task automatic masterResp(input logic nack);
    txAckValid = 1; txNack = nack;
    @(negedge clk);
    txAckValid = 0; txNack = 0;
  endtask

  task automatic doWrite(input int p, input logic [15:0] v);
    pulseStart();
    sendByte(addrByte(PINS, 0)); chk("R1 write address ack", {31'd0, lastAck}, 1);
    sendByte(8'(p));             chk("R3 pointer ack", {31'd0, lastAck}, 1);
    sendByte(v[15:8]);           chk("R4 high byte ack", {31'd0, lastAck}, 1);
    sendByte(v[7:0]);            chk("R4 low byte ack", {31'd0, lastAck}, 1);
    if (RO_M[p]) chk("R5 no write strobe on read-only", {31'd0, lastWrEn}, 0);
    else begin
      chk("R4 write strobe", {31'd0, lastWrEn}, 1);
      chk("R4 write word", {16'd0, regWrData}, {16'd0, v});
      expRegs[p] = v;
    end
    pulseStop();
    expPtr = p;
  endtask

  task automatic doRead(input int p, input bit setPtr);
    logic [7:0] hi, lo;
    pulseStart();
    if (setPtr) begin
      sendByte(addrByte(PINS, 0));
      sendByte(8'(p)); chk("R3 pointer ack before read", {31'd0, lastAck}, 1);
      pulseStart();
      expPtr = p;
    end
    sendByte(addrByte(PINS, 1)); chk("R1 read address ack", {31'd0, lastAck}, 1);
    hi = txData; masterResp(0);
    lo = txData; masterResp(1);
    chk("R6/R7 read word", {16'd0, hi, lo}, {16'd0, expRead(expPtr)});
    chk("R8 read ended by NACK", {31'd0, txActive}, 0);
    pulseStop();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) begin
      regFile[i] = 16'h1100 * 16'(i) + 16'h0033 + 16'(i);
      expRegs[i] = regFile[i];
    end
    void'($urandom(32'd7411));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // Reset state
    chk("R3 pointer after reset", {29'd0, regPtr}, 0);
    chk("R8 idle txData", {24'd0, txData}, 32'hFF);
    chk("R9 idle txActive", {31'd0, txActive}, 0);
    chk("R10 no timeout after reset", {31'd0, timeoutEvt}, 0);

    // Read using the reset pointer
    doRead(0, 0);

    // Wrong device code, then wrong pin bits
    pulseStart();
    sendByte({4'b1010, PINS, 1'b0}); chk("R1 foreign code NACK", {31'd0, lastAck}, 0);
    sendByte(8'h01);                 chk("R1 bytes after mismatch NACK", {31'd0, lastAck}, 0);
    pulseStart();
    sendByte(addrByte(~PINS, 1));    chk("R1 wrong pins NACK", {31'd0, lastAck}, 0);
    chk("R1 no read after mismatch", {31'd0, txActive}, 0);
    pulseStop();

    // Pointer-only write, then plain read
    pulseStart();
    sendByte(addrByte(PINS, 0));
    sendByte(8'h03); chk("R3 pointer-only ack", {31'd0, lastAck}, 1);
    pulseStop();
    expPtr = 3;
    chk("R3 pointer latched", {29'd0, regPtr}, 3);
    doRead(3, 0);

    // Pointer byte with an upper bit set
    pulseStart();
    sendByte(addrByte(PINS, 0));
    sendByte(8'h13); chk("R3 wide pointer NACK", {31'd0, lastAck}, 0);
    chk("R3 pointer unchanged", {29'd0, regPtr}, 3);
    pulseStop();

    // Word write, extra byte, repeated-start readback
    pulseStart();
    sendByte(addrByte(PINS, 0));
    sendByte(8'h04); sendByte(8'hBE); sendByte(8'hEF);
    chk("R4 strobe after low byte", {31'd0, lastWrEn}, 1);
    chk("R4 data high byte first", {16'd0, regWrData}, 32'hBEEF);
    expRegs[4] = 16'hBEEF; expPtr = 4;
    sendByte(8'h55); chk("R4 third data byte NACK", {31'd0, lastAck}, 0);
    chk("R4 no second strobe", {31'd0, lastWrEn}, 0);
    pulseStart();
    sendByte(addrByte(PINS, 1)); chk("R9 repeated start read ack", {31'd0, lastAck}, 1);
    chk("R6 high byte first", {24'd0, txData}, 32'hBE);
    masterResp(0); chk("R6 low byte", {24'd0, txData}, 32'hEF);
    masterResp(0); chk("R6 alternates back to high", {24'd0, txData}, 32'hBE);
    masterResp(0); chk("R6 low again", {24'd0, txData}, 32'hEF);
    masterResp(1); chk("R8 txData released", {24'd0, txData}, 32'hFF);
    sendByte(8'h00); chk("R8 byte after NACK ignored", {31'd0, lastAck}, 0);
    pulseStop();

    // Read-only and write-only registers
    doWrite(5, 16'h1234);
    doRead(5, 1);
    doWrite(2, 16'hCAFE);
    chk("R7 write-only stored", {16'd0, regFile[2]}, 32'hCAFE);
    doRead(2, 1);

    // Stop during a read
    pulseStart();
    sendByte(addrByte(PINS, 1));
    chk("R9 reading before stop", {31'd0, txActive}, 1);
    pulseStop();
    chk("R9 stop ends read", {31'd0, txActive}, 0);

    // Timeout: one cycle short, then past the limit
    pulseStart();
    sendByte(addrByte(PINS, 0));
    lineLow = 1;
    repeat (TO_CYC - 1) @(negedge clk);
    lineLow = 0;
    chk("R10 no timeout below limit", {31'd0, timeoutEvt}, 0);
    sendByte(8'h06); chk("R10 still in transaction", {31'd0, lastAck}, 1);
    expPtr = 6;
    begin
      int firstHit = -1;
      lineLow = 1;
      for (int i = 1; i <= TO_CYC + 2; i++) begin
        @(negedge clk);
        if (timeoutEvt && firstHit < 0) firstHit = i;
      end
      lineLow = 0;
      chk("R10 timeout cycle", 32'(firstHit), 32'(TO_CYC));
    end
    sendByte(8'h11); chk("R10 idle after timeout", {31'd0, lastAck}, 0);
    pulseStart();
    sendByte(addrByte(PINS, 1));
    lineLow = 1;
    repeat (TO_CYC + 1) @(negedge clk);
    lineLow = 0;
    chk("R10 read released", {31'd0, txActive}, 0);
    chk("R10 txData released", {24'd0, txData}, 32'hFF);
    chk("R3 pointer kept over timeout", {29'd0, regPtr}, 32'(expPtr));

    // Random mix
    for (int n = 0; n < 150; n++) begin
      int op = int'($urandom % 3);
      int p  = int'($urandom % NREG);
      logic [15:0] v = 16'($urandom);
      case (op)
        0: doWrite(p, v);
        1: doRead(p, 1);
        default: begin
          pulseStart();
          sendByte(addrByte(PINS, 0));
          sendByte(8'(p));
          pulseStop();
          expPtr = p;
          chk("R3 random pointer", {29'd0, regPtr}, 32'(p));
          doRead(p, 0);
        end
      endcase
    end

    summary();
    $finish;
  end

endmodule